// File: doc/BRIEF.md
# Cyclic Ring-Buffer DMA Channel

This block is one DMA channel that streams 32-bit words between a memory port and a peripheral word port. It is meant for audio-style traffic. Software loads a base address, a period length and a period count through a small register port, then sets the run bit. The channel then walks a ring of equal periods in memory. It raises an interrupt at the end of every period and, in ring mode, wraps back to the base and keeps going until software asks it to stop.

The transfer direction is chosen in the control register. In memory-to-peripheral mode the engine reads a word from memory and hands it to the peripheral. In peripheral-to-memory mode it accepts a word from the peripheral and writes it to memory. Words move in bursts. When flow control is on, a burst starts only while the chosen peripheral request line is high. A stop request lets the burst in flight finish, and only then does the busy status bit drop. A free-running counter of completed periods lets software work out how far the ring has advanced.

Top module: `dma_ring_chan`

## Requirements
- R1: Registers read back as written at their byte offsets: control 0x24, config 0x28, FIFO control 0x2c, source address 0x34, target address 0x3c, period length 0x44. Address registers always read with bits 1:0 as zero. The period length register keeps only bits 29:2, so it counts whole words.
- R2: Writing 1 to bit 0 at offset 0x00 while idle starts the channel, and status bit 0 at offset 0x0c reads 1 from the next cycle. The start is ignored when control bits 15:12 are neither 2 nor 4, or when the period length is zero.
- R3: With control bits 15:12 equal to 4 (memory to peripheral), the word read at source base + 4k is delivered to the peripheral as the k-th word, in order.
- R4: With control bits 15:12 equal to 2 (peripheral to memory), the k-th word accepted from the peripheral is written to target base + 4k.
- R5: The ring holds field+1 periods. The field is config bits 30:28 for memory to peripheral and config bits 26:24 for peripheral to memory. After the last word of the last period, the memory address returns to the base.
- R6: With control bits 9:8 equal to 2 the ring repeats until a stop request. With any other value the channel makes one pass over the ring and then drops busy by itself.
- R7: Config bits 22:20 set the burst length: codes 1 to 5 give 1, 2, 4, 8 and 16 words, and codes 0, 6 and 7 give 16 words. A burst is cut short at the end of a period.
- R8: With control bit 1 set, a burst starts only while the request line is high. The line is chosen by control bits 31:28 for memory to peripheral and bits 27:24 for peripheral to memory. A line index beyond the implemented lines never grants a burst.
- R9: Interrupt status bit 0 (offset 0x10) is set at the end of every period and drives the irq output. Writing 1 to bit 0 at offset 0x1c clears it. If a new period ends in the same cycle as the clear, the status stays set.
- R10: The low PROG_W bits at offset 0x54 count completed periods modulo 2^PROG_W. The count is cleared by an accepted start.
- R11: Writing 0 to bit 0 at offset 0x00 while busy lets the current burst complete, then clears status bit 0, and no further words move. While idle the same write has no effect.
- R12: While busy, writes to the control, config, FIFO control, address and period length registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Period-done interrupt |
| req_lines | input | NUM_REQ | Peripheral request lines |
| mem_req | output | 1 | Memory access request |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access completes this cycle |
| per_rx_valid | input | 1 | Peripheral offers a word |
| per_rx_data | input | 32 | Word from the peripheral |
| per_rx_ready | output | 1 | Channel accepts the offered word |
| per_tx_valid | output | 1 | Channel offers a word to the peripheral |
| per_tx_data | output | 32 | Word to the peripheral |
| per_tx_ready | input | 1 | Peripheral accepts the word |

## Verification
The assertions assume that software leaves the ring parameters alone while the channel is busy. The register block enforces this, so the ring bound is checked against stable values. They also assume that memory and the peripheral complete accesses only through mem_ack and the valid/ready pairs, one word per handshake. The stimulus gives memory a same-cycle acknowledge and a peripheral that is always ready or always valid. Every run is set up from idle with a valid direction and a nonzero period length, except in the case that deliberately tries an illegal start.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;

    localparam int WORD_W = 32;
    localparam int PER_W  = 3;

    // register byte offsets
    localparam logic [7:0] RA_CMD   = 8'h00;
    localparam logic [7:0] RA_STAT  = 8'h0C;
    localparam logic [7:0] RA_ISTAT = 8'h10;
    localparam logic [7:0] RA_ICLR  = 8'h1C;
    localparam logic [7:0] RA_CTRL  = 8'h24;
    localparam logic [7:0] RA_CFG   = 8'h28;
    localparam logic [7:0] RA_FIFO  = 8'h2C;
    localparam logic [7:0] RA_SRC   = 8'h34;
    localparam logic [7:0] RA_TRG   = 8'h3C;
    localparam logic [7:0] RA_TC    = 8'h44;
    localparam logic [7:0] RA_PROG  = 8'h54;

    localparam logic [3:0] DIR_DEV2MEM = 4'd2;
    localparam logic [3:0] DIR_MEM2DEV = 4'd4;
    localparam logic [1:0] MODE_RING   = 2'd2;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_GATE,
        ENG_TAKE,
        ENG_GIVE
    } eng_state_e;

    function automatic logic [4:0] burst_len(input logic [2:0] code);
        case (code)
            3'd1:    burst_len = 5'd1;
            3'd2:    burst_len = 5'd2;
            3'd3:    burst_len = 5'd4;
            3'd4:    burst_len = 5'd8;
            default: burst_len = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/dma_ring_regs.sv
module dma_ring_regs
    import dma_ring_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int PROG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic              busy_i,
    input  logic              period_done_i,
    output logic              start_o,
    output logic              stop_o,
    output logic [3:0]        dir_o,
    output logic [3:0]        tx_idx_o,
    output logic [3:0]        rx_idx_o,
    output logic [1:0]        mode_o,
    output logic              flow_o,
    output logic [PER_W-1:0]  src_per_o,
    output logic [PER_W-1:0]  trg_per_o,
    output logic [2:0]        burst_code_o,
    output logic [31:0]       src_o,
    output logic [31:0]       trg_o,
    output logic [27:0]       tcw_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [31:0]       ctrl;
        logic [31:0]       cfg;
        logic [31:0]       fifo;
        logic [31:0]       src;
        logic [31:0]       trg;
        logic [27:0]       tcw;
        logic              run;
        logic              istat;
        logic [PROG_W-1:0] prog;
    } regs_t;

    regs_t r_d, r_q;
    logic  dir_ok;

    always_comb begin
        r_d     = r_q;
        start_o = 1'b0;
        stop_o  = 1'b0;
        dir_ok  = (r_q.ctrl[15:12] == DIR_DEV2MEM) || (r_q.ctrl[15:12] == DIR_MEM2DEV);
        if (!busy_i) begin
            r_d.run = 1'b0;
        end
        if (wr_en_i) begin
            case (addr_i)
                REG_AW'(RA_CMD): begin
                    if (wdata_i[0]) begin
                        if (!busy_i && dir_ok && (r_q.tcw != '0)) begin
                            start_o  = 1'b1;
                            r_d.run  = 1'b1;
                            r_d.prog = '0;
                        end
                    end else begin
                        r_d.run = 1'b0;
                        stop_o  = busy_i;
                    end
                end
                REG_AW'(RA_ICLR): if (wdata_i[0]) r_d.istat = 1'b0;
                REG_AW'(RA_CTRL): if (!busy_i) r_d.ctrl = wdata_i;
                REG_AW'(RA_CFG):  if (!busy_i) r_d.cfg  = wdata_i;
                REG_AW'(RA_FIFO): if (!busy_i) r_d.fifo = wdata_i;
                REG_AW'(RA_SRC):  if (!busy_i) r_d.src  = {wdata_i[31:2], 2'b00};
                REG_AW'(RA_TRG):  if (!busy_i) r_d.trg  = {wdata_i[31:2], 2'b00};
                REG_AW'(RA_TC):   if (!busy_i) r_d.tcw  = wdata_i[29:2];
                default: ;
            endcase
        end
        // a period end wins over a clear in the same cycle
        if (period_done_i) begin
            r_d.istat = 1'b1;
            r_d.prog  = r_q.prog + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (addr_i)
            REG_AW'(RA_CMD):   rdata_o = {31'd0, r_q.run};
            REG_AW'(RA_STAT):  rdata_o = {31'd0, busy_i};
            REG_AW'(RA_ISTAT): rdata_o = {31'd0, r_q.istat};
            REG_AW'(RA_CTRL):  rdata_o = r_q.ctrl;
            REG_AW'(RA_CFG):   rdata_o = r_q.cfg;
            REG_AW'(RA_FIFO):  rdata_o = r_q.fifo;
            REG_AW'(RA_SRC):   rdata_o = r_q.src;
            REG_AW'(RA_TRG):   rdata_o = r_q.trg;
            REG_AW'(RA_TC):    rdata_o = {2'b00, r_q.tcw, 2'b00};
            REG_AW'(RA_PROG):  rdata_o = 32'(r_q.prog);
            default:           rdata_o = 32'd0;
        endcase
    end

    assign dir_o        = r_q.ctrl[15:12];
    assign tx_idx_o     = r_q.ctrl[31:28];
    assign rx_idx_o     = r_q.ctrl[27:24];
    assign mode_o       = r_q.ctrl[9:8];
    assign flow_o       = r_q.ctrl[1];
    assign src_per_o    = r_q.cfg[28 +: PER_W];
    assign trg_per_o    = r_q.cfg[24 +: PER_W];
    assign burst_code_o = r_q.cfg[22:20];
    assign src_o        = r_q.src;
    assign trg_o        = r_q.trg;
    assign tcw_o        = r_q.tcw;
    assign irq_o        = r_q.istat;

    // R10
    prog_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_o |=> (r_q.prog == $past(r_q.prog)) || (r_q.prog == $past(r_q.prog) + 1'b1));

    // R12
    frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i)) |-> ($stable(r_q.tcw) && $stable(r_q.ctrl) && $stable(r_q.cfg)));

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.istat) |-> $past(period_done_i));

endmodule

// File: rtl/dma_ring_seq.sv
module dma_ring_seq
    import dma_ring_pkg::*;
#(
    parameter int NUM_REQ = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [3:0]         dir_i,
    input  logic [3:0]         tx_idx_i,
    input  logic [3:0]         rx_idx_i,
    input  logic [1:0]         mode_i,
    input  logic               flow_i,
    input  logic [PER_W-1:0]   src_per_i,
    input  logic [PER_W-1:0]   trg_per_i,
    input  logic [2:0]         burst_code_i,
    input  logic [31:0]        src_i,
    input  logic [31:0]        trg_i,
    input  logic [27:0]        tcw_i,
    input  logic [NUM_REQ-1:0] req_lines_i,
    output logic               busy_o,
    output logic               period_done_o,
    output logic               mem_req_o,
    output logic               mem_write_o,
    output logic [31:0]        mem_addr_o,
    output logic [WORD_W-1:0]  mem_wdata_o,
    input  logic [WORD_W-1:0]  mem_rdata_i,
    input  logic               mem_ack_i,
    input  logic               per_rx_valid_i,
    input  logic [WORD_W-1:0]  per_rx_data_i,
    output logic               per_rx_ready_o,
    output logic               per_tx_valid_o,
    output logic [WORD_W-1:0]  per_tx_data_o,
    input  logic               per_tx_ready_i
);

    localparam int OFS_W = 30;

    typedef struct packed {
        eng_state_e        state;
        logic              stop;
        logic [OFS_W-1:0]  ofs;
        logic [27:0]       wcnt;
        logic [PER_W-1:0]  pidx;
        logic [4:0]        blen;
        logic [WORD_W-1:0] data;
    } seq_t;

    seq_t s_d, s_q;

    logic             to_dev;
    logic             ring_mode;
    logic [PER_W-1:0] last_per;
    logic [31:0]      base;
    logic [3:0]       req_idx;
    logic [15:0]      req_ext;
    logic             req_hit;
    logic             fire;
    logic             end_per;
    logic             end_ring;
    logic [31:0]      ring_words;

    always_comb begin
        to_dev     = (dir_i == DIR_MEM2DEV);
        ring_mode  = (mode_i == MODE_RING);
        last_per   = to_dev ? src_per_i : trg_per_i;
        base       = to_dev ? src_i : trg_i;
        req_idx    = to_dev ? tx_idx_i : rx_idx_i;
        req_ext    = 16'(req_lines_i);
        req_hit    = req_ext[req_idx];
        ring_words = (32'(last_per) + 32'd1) * 32'(tcw_i);
        end_per    = (s_q.wcnt == tcw_i - 28'd1);
        end_ring   = (s_q.pidx == last_per);

        s_d            = s_q;
        period_done_o  = 1'b0;
        mem_req_o      = 1'b0;
        mem_write_o    = 1'b0;
        per_rx_ready_o = 1'b0;
        per_tx_valid_o = 1'b0;
        fire           = 1'b0;
        mem_addr_o     = base + {s_q.ofs, 2'b00};
        mem_wdata_o    = s_q.data;
        per_tx_data_o  = s_q.data;

        case (s_q.state)
            ENG_IDLE: begin
                if (start_i) begin
                    s_d.state = ENG_GATE;
                    s_d.stop  = 1'b0;
                    s_d.ofs   = '0;
                    s_d.wcnt  = '0;
                    s_d.pidx  = '0;
                end
            end
            ENG_GATE: begin
                if (s_q.stop) begin
                    s_d.state = ENG_IDLE;
                end else if (!flow_i || req_hit) begin
                    s_d.state = ENG_TAKE;
                    s_d.blen  = burst_len(burst_code_i);
                end
            end
            ENG_TAKE: begin
                if (to_dev) begin
                    mem_req_o = 1'b1;
                    if (mem_ack_i) begin
                        s_d.data  = mem_rdata_i;
                        s_d.state = ENG_GIVE;
                    end
                end else begin
                    per_rx_ready_o = 1'b1;
                    if (per_rx_valid_i) begin
                        s_d.data  = per_rx_data_i;
                        s_d.state = ENG_GIVE;
                    end
                end
            end
            ENG_GIVE: begin
                if (to_dev) begin
                    per_tx_valid_o = 1'b1;
                    fire           = per_tx_ready_i;
                end else begin
                    mem_req_o   = 1'b1;
                    mem_write_o = 1'b1;
                    fire        = mem_ack_i;
                end
                if (fire) begin
                    if (end_per) begin
                        period_done_o = 1'b1;
                        s_d.wcnt      = '0;
                        if (end_ring) begin
                            s_d.pidx = '0;
                            s_d.ofs  = '0;
                        end else begin
                            s_d.pidx = s_q.pidx + 1'b1;
                            s_d.ofs  = s_q.ofs + 1'b1;
                        end
                        s_d.state = (end_ring && !ring_mode) ? ENG_IDLE : ENG_GATE;
                    end else begin
                        s_d.wcnt  = s_q.wcnt + 1'b1;
                        s_d.ofs   = s_q.ofs + 1'b1;
                        s_d.blen  = s_q.blen - 1'b1;
                        s_d.state = (s_q.blen == 5'd1) ? ENG_GATE : ENG_TAKE;
                    end
                end
            end
            default: s_d.state = ENG_IDLE;
        endcase

        if (stop_i && (s_q.state != ENG_IDLE)) begin
            s_d.stop = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.state != ENG_IDLE);

    // R3 R4
    one_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_o, per_tx_valid_o, per_rx_ready_o}));

    // R5
    ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (32'(s_q.ofs) < ring_words));

    // R11
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(s_q.stop) || !$past(ring_mode)));

    // R8
    flow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ENG_TAKE && $past(s_q.state) == ENG_GATE && flow_i) |-> $past(req_hit));

endmodule

// File: rtl/dma_ring_chan.sv
module dma_ring_chan
    import dma_ring_pkg::*;
#(
    parameter int REG_AW  = 8,
    parameter int PROG_W  = 16,
    parameter int NUM_REQ = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq,
    input  logic [NUM_REQ-1:0] req_lines,
    output logic               mem_req,
    output logic               mem_write,
    output logic [31:0]        mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata,
    input  logic               mem_ack,
    input  logic               per_rx_valid,
    input  logic [31:0]        per_rx_data,
    output logic               per_rx_ready,
    output logic               per_tx_valid,
    output logic [31:0]        per_tx_data,
    input  logic               per_tx_ready
);

    logic             busy, period_done, start, stop, flow;
    logic [3:0]       dir, tx_idx, rx_idx;
    logic [1:0]       mode;
    logic [PER_W-1:0] src_per, trg_per;
    logic [2:0]       burst_code;
    logic [31:0]      src, trg;
    logic [27:0]      tcw;

    dma_ring_regs #(.REG_AW(REG_AW), .PROG_W(PROG_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (reg_wr),
        .addr_i        (reg_addr),
        .wdata_i       (reg_wdata),
        .rdata_o       (reg_rdata),
        .busy_i        (busy),
        .period_done_i (period_done),
        .start_o       (start),
        .stop_o        (stop),
        .dir_o         (dir),
        .tx_idx_o      (tx_idx),
        .rx_idx_o      (rx_idx),
        .mode_o        (mode),
        .flow_o        (flow),
        .src_per_o     (src_per),
        .trg_per_o     (trg_per),
        .burst_code_o  (burst_code),
        .src_o         (src),
        .trg_o         (trg),
        .tcw_o         (tcw),
        .irq_o         (irq)
    );

    dma_ring_seq #(.NUM_REQ(NUM_REQ)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .stop_i         (stop),
        .dir_i          (dir),
        .tx_idx_i       (tx_idx),
        .rx_idx_i       (rx_idx),
        .mode_i         (mode),
        .flow_i         (flow),
        .src_per_i      (src_per),
        .trg_per_i      (trg_per),
        .burst_code_i   (burst_code),
        .src_i          (src),
        .trg_i          (trg),
        .tcw_i          (tcw),
        .req_lines_i    (req_lines),
        .busy_o         (busy),
        .period_done_o  (period_done),
        .mem_req_o      (mem_req),
        .mem_write_o    (mem_write),
        .mem_addr_o     (mem_addr),
        .mem_wdata_o    (mem_wdata),
        .mem_rdata_i    (mem_rdata),
        .mem_ack_i      (mem_ack),
        .per_rx_valid_i (per_rx_valid),
        .per_rx_data_i  (per_rx_data),
        .per_rx_ready_o (per_rx_ready),
        .per_tx_valid_o (per_tx_valid),
        .per_tx_data_o  (per_tx_data),
        .per_tx_ready_i (per_tx_ready)
    );

endmodule

// File: tb/dma_ring_chan_test.sv
module dma_ring_chan_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [10:0] req_lines = '0;
    logic        mem_req, mem_write, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        per_rx_valid, per_rx_ready, per_tx_valid;
    logic        per_tx_ready = 1'b1;
    logic [31:0] per_rx_data, per_tx_data;
    logic        rx_en = 1'b0;
    logic [31:0] rx_seq = 32'h5000_0000;

    always #10 clk = ~clk;

    dma_ring_chan #(.PROG_W(6)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .req_lines(req_lines), .mem_req(mem_req), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .per_rx_valid(per_rx_valid), .per_rx_data(per_rx_data),
        .per_rx_ready(per_rx_ready), .per_tx_valid(per_tx_valid),
        .per_tx_data(per_tx_data), .per_tx_ready(per_tx_ready)
    );

    function automatic logic [31:0] memval(input logic [31:0] a);
        return a ^ 32'hC0DE_0000;
    endfunction

    assign mem_ack      = mem_req;
    assign mem_rdata    = memval(mem_addr);
    assign per_rx_valid = rx_en;
    assign per_rx_data  = rx_seq;
    always @(posedge clk) if (per_rx_valid && per_rx_ready) rx_seq <= rx_seq + 1;

    typedef struct { logic wr; logic [31:0] addr; logic [31:0] data; } item_t;
    item_t exp_q[$];
    int checks = 0, errors = 0, n_seen = 0;

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    task automatic observe(input logic wr, input logic [31:0] a, input logic [31:0] d);
        item_t it;
        n_seen++;
        if (exp_q.size() == 0) begin
            chk_eq("R3/R4 unexpected word", d, 32'hxxxx_xxxx);
        end else begin
            it = exp_q.pop_front();
            chk_eq("R3/R4 word kind", {31'd0, wr}, {31'd0, it.wr});
            if (wr) chk_eq("R4 R5 write address", a, it.addr);
            chk_eq("R3/R4 word data", d, it.data);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        if (per_tx_valid && per_tx_ready) observe(1'b0, 32'd0, per_tx_data);
        if (mem_req && mem_write && mem_ack) observe(1'b1, mem_addr, mem_wdata);
    end

    // drivers: push expected items
    task automatic push_to_dev(input logic [31:0] base, input int ring, input int n);
        for (int k = 0; k < n; k++) begin
            item_t it;
            it.wr = 1'b0; it.addr = base + 32'(4 * (k % ring));
            it.data = memval(it.addr);
            exp_q.push_back(it);
        end
    endtask

    task automatic push_to_mem(input logic [31:0] base, input int ring, input int n, input logic [31:0] first);
        for (int k = 0; k < n; k++) begin
            item_t it;
            it.wr = 1'b1; it.addr = base + 32'(4 * (k % ring));
            it.data = first + 32'(k);
            exp_q.push_back(it);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            rd(8'h0C, v);
            if (v[0] == 1'b0) return;
        end
        chk_eq("R11 channel never went idle", 32'd1, 32'd0);
    endtask

    task automatic wait_seen(input int n);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (n_seen >= n) return;
        end
        chk_eq("R3/R4 words never arrived", 32'(n_seen), 32'(n));
    endtask

    task automatic new_run();
        exp_q.delete();
        n_seen = 0;
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [31:0] v, s;
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(8'h0C, v); chk_eq("R2 status after reset", v, 32'd0);
        chk_eq("R9 irq after reset", {31'd0, irq}, 32'd0);
        chk_eq("R3 no traffic after reset", {30'd0, mem_req, per_tx_valid}, 32'd0);
        rd(8'h54, v); chk_eq("R10 progress after reset", v, 32'd0);

        // R1 readback
        wr(8'h34, 32'h0000_1003); rd(8'h34, v); chk_eq("R1 source addr aligned", v, 32'h0000_1000);
        wr(8'h3C, 32'hFFFF_FFFF); rd(8'h3C, v); chk_eq("R1 target addr aligned", v, 32'hFFFF_FFFC);
        wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, v); chk_eq("R1 period length bits", v, 32'h3FFF_FFFC);
        wr(8'h2C, 32'h0101_0303); rd(8'h2C, v); chk_eq("R1 fifo ctrl", v, 32'h0101_0303);
        wr(8'h28, 32'h2050_0001); rd(8'h28, v); chk_eq("R1 config", v, 32'h2050_0001);

        // R2 illegal starts
        wr(8'h24, 32'h0000_3200); wr(8'h44, 32'd4); wr(8'h00, 32'd1);
        repeat (3) @(negedge clk);
        rd(8'h0C, v); chk_eq("R2 bad direction ignored", v, 32'd0);
        chk_eq("R2 no traffic on bad start", {31'd0, mem_req}, 32'd0);
        wr(8'h24, 32'h0000_4000); wr(8'h44, 32'd0); wr(8'h00, 32'd1);
        repeat (3) @(negedge clk);
        rd(8'h0C, v); chk_eq("R2 zero length ignored", v, 32'd0);

        // R6 one pass, memory to peripheral, burst 2 cut by period of 3
        new_run();
        wr(8'h24, 32'h0000_4000); wr(8'h28, 32'h2020_0001);
        wr(8'h44, 32'd12); wr(8'h34, 32'h0000_1000);
        push_to_dev(32'h0000_1000, 9, 9);
        wr(8'h00, 32'd1);
        rd(8'h0C, v); chk_eq("R2 busy after start", v, 32'd1);
        wait_idle();
        chk_eq("R6 R7 one pass word count", 32'(n_seen), 32'd9);
        rd(8'h54, v); chk_eq("R10 periods after one pass", v, 32'd3);
        rd(8'h10, v); chk_eq("R9 interrupt status set", v, 32'd1);
        chk_eq("R9 irq pin set", {31'd0, irq}, 32'd1);
        wr(8'h1C, 32'd1);
        rd(8'h10, v); chk_eq("R9 interrupt cleared", v, 32'd0);

        // R5 ring wrap, R11 stop drain, R12 frozen regs
        new_run();
        wr(8'h24, 32'h0000_4200); wr(8'h28, 32'h1050_0000);
        wr(8'h44, 32'd16); wr(8'h34, 32'h0000_3000);
        push_to_dev(32'h0000_3000, 8, 60);
        wr(8'h00, 32'd1);
        wr(8'h44, 32'h0000_0100);
        rd(8'h44, v); chk_eq("R12 length write ignored while busy", v, 32'd16);
        wr(8'h34, 32'h0000_7000);
        rd(8'h34, v); chk_eq("R12 address write ignored while busy", v, 32'h0000_3000);
        wait_seen(20);
        wr(8'h00, 32'd0);
        wait_idle();
        chk_eq("R11 stop drains whole burst", 32'(n_seen % 4), 32'd0);
        rd(8'h54, v); chk_eq("R10 periods after stop", v, 32'((n_seen / 4) % 64));
        seen = n_seen;
        repeat (20) @(negedge clk);
        chk_eq("R11 no words after stop", 32'(n_seen), 32'(seen));
        wr(8'h00, 32'd0);
        rd(8'h0C, v); chk_eq("R11 stop while idle no effect", v, 32'd0);

        // R8 flow control, peripheral to memory, burst code 0 clamps to 16
        new_run();
        wr(8'h24, 32'h0300_2202); wr(8'h28, 32'h0000_0000);
        wr(8'h44, 32'd32); wr(8'h3C, 32'h0000_2000);
        rx_en = 1'b1;
        s = rx_seq;
        push_to_mem(32'h0000_2000, 8, 60, s);
        wr(8'h00, 32'd1);
        rd(8'h54, v); chk_eq("R10 progress cleared by start", v, 32'd0);
        repeat (20) @(negedge clk);
        chk_eq("R8 no burst without request", 32'(n_seen), 32'd0);
        req_lines = 11'b000_0001_0000;
        repeat (20) @(negedge clk);
        chk_eq("R8 other line does not grant", 32'(n_seen), 32'd0);
        req_lines = 11'b000_0000_1000;
        wait_seen(24);
        wr(8'h00, 32'd0);
        wait_idle();
        chk_eq("R7 R11 drain to period end", 32'(n_seen % 8), 32'd0);
        rd(8'h54, v); chk_eq("R10 periods flow run", v, 32'(n_seen / 8));
        req_lines = '0;

        // R10 wrap of the progress counter (PROG_W = 6)
        new_run();
        wr(8'h24, 32'h0000_2200); wr(8'h28, 32'h0010_0000);
        wr(8'h44, 32'd4); wr(8'h3C, 32'h0000_4000);
        s = rx_seq;
        push_to_mem(32'h0000_4000, 1, 100, s);
        wr(8'h00, 32'd1);
        wait_seen(70);
        wr(8'h00, 32'd0);
        wait_idle();
        rd(8'h54, v); chk_eq("R10 progress wraps", v, 32'(n_seen % 64));
        rd(8'h10, v); chk_eq("R9 status after run", v, 32'd1);
        rx_en = 1'b0;

        finish_up();
    end

endmodule